// File: doc/BRIEF.md
# Multiplexed GPIO Pin Bank

This block controls a bank of bidirectional pins arranged as 8-bit ports, five by default, giving 40 pins. Each pin has a 2-bit function code. Code 0 makes the pin a plain GPIO driven from the port's direction and output-latch registers. Codes 1, 2 and 3 hand the pin's output value and output enable to one of three peripheral sources. Every pin's input goes through a two-stage synchroniser. The synchronised level can be read back at any time, whatever function the pin is assigned to.

Pull-up control is writable only on part of the bank; every other pin keeps its pull-up on. A sleep input freezes the pad drive stage. A soft-reset input models a watchdog or software reset. A retention bit decides whether that reset wipes the port configuration or leaves it untouched. The hard reset always restores the defaults. One designated pin feeds a conversion-start output that follows the pin no matter which function code is selected on it.

The register interface is a single-cycle write strobe with a combinational read. `addr[5:3]` selects the port, with 7 selecting the global control word. `addr[2:0]` selects a register within the port:

| Index | Register | Write | Read |
|---|---|---|---|
| 0 | function codes | 16 bits | 16 bits |
| 1 | direction | 8 bits | 8 bits |
| 2 | data | output latch | synchronised pin levels |
| 3 | set | 1 bits set latch bits | 0 |
| 4 | clear | 1 bits clear latch bits | 0 |
| 5 | pull-up | 8 bits | 8 bits |

Top module: `pinmux_bank`

## Requirements
- R1: After hard reset every function code, direction bit and output-latch bit is 0 and every pull-up bit is 1. The retention bit is 0, and `pad_oe`, `pad_out`, `periph_in` and `conv_start` are all 0.
- R2: For a pin with function code 0, `pad_oe` equals its direction bit and `pad_out` equals its output-latch bit. Both appear one clock after the register holds the value.
- R3: Function codes 1, 2 and 3 route `alt1_*`, `alt2_*` and `alt3_*` respectively to the pin's `pad_out` and `pad_oe`, one clock after the inputs change. The code for pin b of a port sits in bits [2b+1:2b] of register 0.
- R4: Reading register 2 returns the port's `pad_in` level as it was two clock edges earlier, in every function mode. After one edge, the old level is still returned.
- R5: A write to register 3 sets the latch bits written as 1. A write to register 4 clears the latch bits written as 1. Bits written as 0 are unchanged, and reads of registers 3 and 4 return 0.
- R6: Pull-up bits are writable only on port 0 bits 0, 4, 5, 6, 7 and on all of port 1. Every other pull-up bit reads as 1 and drives `pad_pu` high whatever is written.
- R7: While `sleep` is high, `pad_out` and `pad_oe` hold their values, even if registers or peripheral inputs change. Once `sleep` falls they follow again after one clock.
- R8: The retention bit is bit 0 of port 7, register 0. A `soft_rst` pulse with the retention bit at 0 restores the R1 defaults of all port registers. With the bit at 1 it changes nothing, and the retention bit itself survives `soft_rst`.
- R9: Hard reset restores the R1 defaults, and clears the retention bit, even when the retention bit is 1.
- R10: `conv_start` follows the synchronised level of pin `CONV_PIN` in every function mode. `periph_in[i]` is the synchronised level of pin i when its code is nonzero, and 0 when its code is 0.
- R11: Reads of unmapped registers, including ports 5 and 6 and register indexes 6 and 7, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hard reset, active high |
| soft_rst | input | 1 | Watchdog or software reset pulse |
| sleep | input | 1 | Power-saving state; freezes pad drive |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Port index [5:3], register index [2:0] |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data |
| pad_in | input | 40 | Raw pin input levels |
| pad_out | output | 40 | Pin output value |
| pad_oe | output | 40 | Pin output enable |
| pad_pu | output | 40 | Pin pull-up enable |
| alt1_out | input | 40 | Peripheral source 1 output value |
| alt1_oe | input | 40 | Peripheral source 1 output enable |
| alt2_out | input | 40 | Peripheral source 2 output value |
| alt2_oe | input | 40 | Peripheral source 2 output enable |
| alt3_out | input | 40 | Peripheral source 3 output value |
| alt3_oe | input | 40 | Peripheral source 3 output enable |
| periph_in | output | 40 | Synchronised pin levels gated to peripheral mode |
| conv_start | output | 1 | Always-live synchronised input of pin CONV_PIN |

## Verification
The assertions check the following on every cycle:
- the frozen pad drive during sleep;
- the reset defaults seen at the pull-up and peripheral outputs after a hard reset or an unretained soft reset;
- that pull-ups are unchanged by a retained soft reset;
- the two-cycle delay from the conversion-start pin to its output.

Only the bench scenarios can show that each function code routes the right source, that the set and clear masks touch only the bits written, and that the pull-up mask matches the stated pin subset. The same holds for readback of live levels while pins are in peripheral mode.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

    localparam int PORT_W   = 8;
    localparam int DATA_W   = 2 * PORT_W;
    localparam int ADDR_W   = 6;
    localparam int SEL_W    = 3;
    localparam logic [SEL_W-1:0] GLOBAL_PORT = 3'd7;

    typedef enum logic [1:0] {
        FS_GPIO = 2'b00,
        FS_ALT1 = 2'b01,
        FS_ALT2 = 2'b10,
        FS_ALT3 = 2'b11
    } fsel_e;

    typedef enum logic [2:0] {
        RG_CFG  = 3'd0,
        RG_DIR  = 3'd1,
        RG_DATA = 3'd2,
        RG_SET  = 3'd3,
        RG_CLR  = 3'd4,
        RG_PULL = 3'd5
    } reg_e;

    typedef struct packed {
        logic oe;
        logic val;
    } drive_t;

    // Pins whose pull-up may be switched off by software.
    function automatic logic [PORT_W-1:0] pull_mask(input int port);
        case (port)
            0:       return 8'hF1;
            1:       return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic drive_t pick_drive(input fsel_e sel, input drive_t gp,
                                          input drive_t f1, input drive_t f2,
                                          input drive_t f3);
        case (sel)
            FS_ALT1: return f1;
            FS_ALT2: return f2;
            FS_ALT3: return f3;
            default: return gp;
        endcase
    endfunction

endpackage

// File: rtl/pinmux_sync.sv
module pinmux_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/pinmux_port.sv
module pinmux_port
    import pinmux_pkg::*;
#(
    parameter int PORT_IDX = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic                wr_en,
    input  logic [2:0]          reg_sel,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   fsel,
    output logic [PORT_W-1:0]   dir,
    output logic [PORT_W-1:0]   dout,
    output logic [PORT_W-1:0]   pull
);
    localparam logic [PORT_W-1:0] MASK = pull_mask(PORT_IDX);

    logic [DATA_W-1:0] fsel_q;
    logic [PORT_W-1:0] dir_q;
    logic [PORT_W-1:0] dout_q;
    logic [PORT_W-1:0] pull_q;
    logic [PORT_W-1:0] wbyte;

    assign wbyte = wdata[PORT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fsel_q <= '0;
            dir_q  <= '0;
            dout_q <= '0;
            pull_q <= '1;
        end else if (wr_en) begin
            case (reg_e'(reg_sel))
                RG_CFG:  fsel_q <= wdata;
                RG_DIR:  dir_q  <= wbyte;
                RG_DATA: dout_q <= wbyte;
                RG_SET:  dout_q <= dout_q | wbyte;
                RG_CLR:  dout_q <= dout_q & ~wbyte;
                RG_PULL: pull_q <= (wbyte & MASK) | ~MASK;
                default: ;
            endcase
        end
    end

    assign fsel = fsel_q;
    assign dir  = dir_q;
    assign dout = dout_q;
    assign pull = pull_q;
endmodule

// File: rtl/pinmux_drive.sv
module pinmux_drive
    import pinmux_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic [DATA_W-1:0] fsel,
    input  logic [PORT_W-1:0] dir,
    input  logic [PORT_W-1:0] dout,
    input  logic [PORT_W-1:0] a1_out,
    input  logic [PORT_W-1:0] a1_oe,
    input  logic [PORT_W-1:0] a2_out,
    input  logic [PORT_W-1:0] a2_oe,
    input  logic [PORT_W-1:0] a3_out,
    input  logic [PORT_W-1:0] a3_oe,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe
);
    drive_t            nxt [PORT_W];
    logic [PORT_W-1:0] out_q;
    logic [PORT_W-1:0] oe_q;

    for (genvar b = 0; b < PORT_W; b++) begin : g_pin
        assign nxt[b] = pick_drive(fsel_e'(fsel[2*b +: 2]),
                                   drive_t'{dir[b],   dout[b]},
                                   drive_t'{a1_oe[b], a1_out[b]},
                                   drive_t'{a2_oe[b], a2_out[b]},
                                   drive_t'{a3_oe[b], a3_out[b]});
    end

    // Pad stage: frozen while the device sleeps.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            oe_q  <= '0;
        end else if (!hold) begin
            for (int b = 0; b < PORT_W; b++) begin
                out_q[b] <= nxt[b].val;
                oe_q[b]  <= nxt[b].oe;
            end
        end
    end

    assign pad_out = out_q;
    assign pad_oe  = oe_q;
endmodule

// File: rtl/pinmux_bank.sv
module pinmux_bank
    import pinmux_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int CONV_PIN  = 16,
    localparam int NPINS    = NUM_PORTS * PORT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              sleep,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_pu,
    input  logic [NPINS-1:0]  alt1_out,
    input  logic [NPINS-1:0]  alt1_oe,
    input  logic [NPINS-1:0]  alt2_out,
    input  logic [NPINS-1:0]  alt2_oe,
    input  logic [NPINS-1:0]  alt3_out,
    input  logic [NPINS-1:0]  alt3_oe,
    output logic [NPINS-1:0]  periph_in,
    output logic              conv_start
);
    logic [SEL_W-1:0]  a_port;
    logic [2:0]        a_reg;
    logic              retain_q;
    logic              soft_clear;
    logic [NPINS-1:0]  sync_in;
    logic [DATA_W-1:0] fsel_all [NUM_PORTS];
    logic [PORT_W-1:0] dir_all  [NUM_PORTS];
    logic [PORT_W-1:0] dout_all [NUM_PORTS];
    logic [PORT_W-1:0] pull_all [NUM_PORTS];

    assign a_port     = addr[ADDR_W-1:3];
    assign a_reg      = addr[2:0];
    assign soft_clear = soft_rst && !retain_q;

    // Retention control survives soft reset; only hard reset clears it.
    always_ff @(posedge clk) begin
        if (rst) begin
            retain_q <= 1'b0;
        end else if (wr_en && a_port == GLOBAL_PORT && a_reg == RG_CFG) begin
            retain_q <= wdata[0];
        end
    end

    pinmux_sync #(.W(NPINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (sync_in)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam int LO = p * PORT_W;
        logic hit;

        assign hit = wr_en && (a_port == SEL_W'(p));

        pinmux_port #(.PORT_IDX(p)) u_regs (
            .clk     (clk),
            .rst     (rst),
            .clear   (soft_clear),
            .wr_en   (hit),
            .reg_sel (a_reg),
            .wdata   (wdata),
            .fsel    (fsel_all[p]),
            .dir     (dir_all[p]),
            .dout    (dout_all[p]),
            .pull    (pull_all[p])
        );

        pinmux_drive u_drv (
            .clk     (clk),
            .rst     (rst),
            .hold    (sleep),
            .fsel    (fsel_all[p]),
            .dir     (dir_all[p]),
            .dout    (dout_all[p]),
            .a1_out  (alt1_out[LO +: PORT_W]),
            .a1_oe   (alt1_oe[LO +: PORT_W]),
            .a2_out  (alt2_out[LO +: PORT_W]),
            .a2_oe   (alt2_oe[LO +: PORT_W]),
            .a3_out  (alt3_out[LO +: PORT_W]),
            .a3_oe   (alt3_oe[LO +: PORT_W]),
            .pad_out (pad_out[LO +: PORT_W]),
            .pad_oe  (pad_oe[LO +: PORT_W])
        );

        assign pad_pu[LO +: PORT_W] = pull_all[p];

        for (genvar b = 0; b < PORT_W; b++) begin : g_in
            assign periph_in[LO + b] =
                (fsel_e'(fsel_all[p][2*b +: 2]) != FS_GPIO) && sync_in[LO + b];
        end
    end

    assign conv_start = sync_in[CONV_PIN];

    always_comb begin
        rdata = '0;
        if (a_port == GLOBAL_PORT) begin
            if (a_reg == RG_CFG) rdata[0] = retain_q;
        end else begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (a_port == SEL_W'(p)) begin
                    case (reg_e'(a_reg))
                        RG_CFG:  rdata = fsel_all[p];
                        RG_DIR:  rdata[PORT_W-1:0] = dir_all[p];
                        RG_DATA: rdata[PORT_W-1:0] = sync_in[p*PORT_W +: PORT_W];
                        RG_PULL: rdata[PORT_W-1:0] = pull_all[p];
                        default: ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/pinmux_bank_chk.sv
module pinmux_bank_chk #(
    parameter int NPINS    = 40,
    parameter int CONV_PIN = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             soft_rst,
    input logic             sleep,
    input logic             wr_en,
    input logic             retain_q,
    input logic [NPINS-1:0] pad_in,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] pad_pu,
    input logic [NPINS-1:0] periph_in,
    input logic             conv_start
);
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst)             age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // R1 / R9: defaults visible right after a hard reset edge
    p_hard_defaults_r1: assert property (@(posedge clk)
        $past(rst) |-> (pad_oe == '0 && pad_out == '0 && (&pad_pu) && periph_in == '0));

    // R7: pad drive frozen while sleeping
    p_sleep_hold_r7: assert property (@(posedge clk) disable iff (rst)
        sleep |=> ($stable(pad_out) && $stable(pad_oe)));

    // R8: unretained soft reset restores defaults
    p_soft_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (soft_rst && !retain_q) |=> ((&pad_pu) && periph_in == '0));

    // R8: retained soft reset keeps pull-up state
    p_soft_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (soft_rst && retain_q && !wr_en) |=> $stable(pad_pu));

    // R10: conversion-start input is always live, two stages behind the pin
    p_conv_live_r10: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (conv_start == $past(pad_in[CONV_PIN], 2)));
endmodule

bind pinmux_bank pinmux_bank_chk #(.NPINS(NPINS), .CONV_PIN(CONV_PIN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .soft_rst   (soft_rst),
    .sleep      (sleep),
    .wr_en      (wr_en),
    .retain_q   (retain_q),
    .pad_in     (pad_in),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .pad_pu     (pad_pu),
    .periph_in  (periph_in),
    .conv_start (conv_start)
);

// File: tb/pinmux_bank_tb.sv
module pinmux_bank_tb;
    localparam int NP    = 5;
    localparam int NPINS = NP * 8;
    localparam int CONV  = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             soft_rst = 1'b0;
    logic             sleep = 1'b0;
    logic             wr_en = 1'b0;
    logic [5:0]       addr = '0;
    logic [15:0]      wdata = '0;
    logic [15:0]      rdata;
    logic [NPINS-1:0] pad_in = '0;
    logic [NPINS-1:0] pad_out, pad_oe, pad_pu, periph_in;
    logic [NPINS-1:0] a1o = '0, a1e = '0, a2o = '0, a2e = '0, a3o = '0, a3e = '0;
    logic             conv_start;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    pinmux_bank #(.NUM_PORTS(NP), .CONV_PIN(CONV)) u_dut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .sleep(sleep),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .alt1_out(a1o), .alt1_oe(a1e), .alt2_out(a2o), .alt2_oe(a2e),
        .alt3_out(a3o), .alt3_oe(a3e), .periph_in(periph_in),
        .conv_start(conv_start)
    );

    // Behavioural model of the register state
    logic [1:0]       m_fsel [NPINS];
    logic [NPINS-1:0] m_dir, m_dout, m_pull;
    logic             m_retain;

    function automatic logic [7:0] free_pulls(input int port);
        if (port == 0) return 8'b1111_0001;
        if (port == 1) return 8'hFF;
        return 8'h00;
    endfunction

    task automatic model_clear_ports();
        for (int i = 0; i < NPINS; i++) m_fsel[i] = 2'b00;
        m_dir = '0; m_dout = '0; m_pull = '1;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_drive(input int i);
        case (m_fsel[i])
            2'd0: return {m_dir[i], m_dout[i]};
            2'd1: return {a1e[i], a1o[i]};
            2'd2: return {a2e[i], a2o[i]};
            default: return {a3e[i], a3o[i]};
        endcase
    endfunction

    task automatic check_pads(input string req);
        logic [NPINS-1:0] eo, ee, ep;
        for (int i = 0; i < NPINS; i++) begin
            logic [1:0] d;
            d = exp_drive(i);
            ee[i] = d[1];
            eo[i] = d[0];
        end
        ep = m_pull;
        chk({req, " pad_out"}, 64'(pad_out), 64'(eo));
        chk({req, " pad_oe"},  64'(pad_oe),  64'(ee));
        chk({req, " pad_pu"},  64'(pad_pu),  64'(ep));
    endtask

    task automatic check_periph(input string req);
        logic [NPINS-1:0] ep;
        for (int i = 0; i < NPINS; i++) ep[i] = (m_fsel[i] != 2'b00) && pad_in[i];
        chk({req, " periph_in"}, 64'(periph_in), 64'(ep));
        chk({req, " conv_start"}, 64'(conv_start), 64'(pad_in[CONV]));
    endtask

    // Drive one write; returns at the negedge after the write edge.
    task automatic do_write(input int port, input int rg, input logic [15:0] d);
        addr  = {3'(port), 3'(rg)};
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (port < NP) begin
            case (rg)
                0: for (int b = 0; b < 8; b++) m_fsel[port*8+b] = d[2*b +: 2];
                1: m_dir[port*8 +: 8] = d[7:0];
                2: m_dout[port*8 +: 8] = d[7:0];
                3: m_dout[port*8 +: 8] = m_dout[port*8 +: 8] | d[7:0];
                4: m_dout[port*8 +: 8] = m_dout[port*8 +: 8] & ~d[7:0];
                5: m_pull[port*8 +: 8] = (d[7:0] & free_pulls(port)) | ~free_pulls(port);
                default: ;
            endcase
        end else if (port == 7 && rg == 0) begin
            m_retain = d[0];
        end
    endtask

    task automatic rd_check(input int port, input int rg, input logic [15:0] exp, input string req);
        addr = {3'(port), 3'(rg)};
        #1;
        chk(req, 64'(rdata), 64'(exp));
    endtask

    task automatic hard_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear_ports();
        m_retain = 1'b0;
    endtask

    task automatic soft_pulse();
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        if (!m_retain) model_clear_ports();
    endtask

    task automatic randomize_alts();
        a1o = NPINS'({$urandom(), $urandom()});
        a1e = NPINS'({$urandom(), $urandom()});
        a2o = NPINS'({$urandom(), $urandom()});
        a2e = NPINS'({$urandom(), $urandom()});
        a3o = NPINS'({$urandom(), $urandom()});
        a3e = NPINS'({$urandom(), $urandom()});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [NPINS-1:0] snap_o, snap_e;
        logic [NPINS-1:0] old_in;
        void'($urandom(32'h5eed_0042));
        model_clear_ports();
        m_retain = 1'b0;
        @(negedge clk);
        hard_reset();

        // R1: reset state
        check_pads("R1");
        check_periph("R1");
        for (int p = 0; p < NP; p++) begin
            rd_check(p, 0, 16'h0000, "R1 cfg");
            rd_check(p, 1, 16'h0000, "R1 dir");
            rd_check(p, 5, 16'h00FF, "R1 pull");
        end
        rd_check(7, 0, 16'h0000, "R1 retain");

        // R11: unmapped reads
        rd_check(5, 0, 16'h0000, "R11 port5");
        rd_check(6, 1, 16'h0000, "R11 port6");
        rd_check(0, 6, 16'h0000, "R11 reg6");
        rd_check(2, 7, 16'h0000, "R11 reg7");

        // R2: GPIO path
        do_write(2, 1, 16'h00A5);
        do_write(2, 2, 16'h003C);
        rd_check(2, 1, 16'h00A5, "R2 dir readback");
        @(negedge clk);
        check_pads("R2");

        // R5: set / clear
        do_write(2, 1, 16'h00FF);
        do_write(2, 3, 16'h0003);
        @(negedge clk);
        chk("R5 set", 64'(pad_out[23:16]), 64'(8'h3F));
        do_write(2, 4, 16'h0030);
        @(negedge clk);
        chk("R5 clear", 64'(pad_out[23:16]), 64'(8'h0F));
        rd_check(2, 3, 16'h0000, "R5 set reads 0");
        rd_check(2, 4, 16'h0000, "R5 clear reads 0");

        // R3: alternate functions, codes per pin 0,1,2,3,0,1,2,3
        randomize_alts();
        do_write(3, 0, 16'hE4E4);
        rd_check(3, 0, 16'hE4E4, "R3 cfg readback");
        @(negedge clk);
        check_pads("R3");
        randomize_alts();
        @(negedge clk);
        check_pads("R3 alt change");

        // R4: input readback with latency, including alternate-mode port 3
        old_in = pad_in;
        pad_in = NPINS'({$urandom(), $urandom()});
        @(negedge clk);
        rd_check(3, 2, 16'(old_in[31:24]), "R4 one edge");
        @(negedge clk);
        for (int p = 0; p < NP; p++) rd_check(p, 2, 16'(pad_in[p*8 +: 8]), "R4 two edges");
        check_periph("R10");

        // R10: conv pin in alternate mode
        do_write(2, 0, 16'h0003);
        pad_in[CONV] = ~pad_in[CONV];
        @(negedge clk);
        @(negedge clk);
        check_periph("R10 alt");

        // R6: pull-up programmability
        for (int p = 0; p < NP; p++) do_write(p, 5, 16'h0000);
        rd_check(0, 5, 16'h000E, "R6 port0");
        rd_check(1, 5, 16'h0000, "R6 port1");
        rd_check(3, 5, 16'h00FF, "R6 port3 fixed");
        @(negedge clk);
        check_pads("R6");

        // R7: sleep hold
        snap_o = pad_out;
        snap_e = pad_oe;
        sleep = 1'b1;
        @(negedge clk);
        do_write(2, 2, 16'h00C3);
        randomize_alts();
        @(negedge clk);
        @(negedge clk);
        chk("R7 hold out", 64'(pad_out), 64'(snap_o));
        chk("R7 hold oe", 64'(pad_oe), 64'(snap_e));
        sleep = 1'b0;
        @(negedge clk);
        check_pads("R7 wake");

        // R8: soft reset without retention
        soft_pulse();
        @(negedge clk);
        check_pads("R8 cleared");
        rd_check(3, 0, 16'h0000, "R8 cfg cleared");

        // R8: soft reset with retention
        do_write(1, 0, 16'h5A5A);
        do_write(1, 1, 16'h00F0);
        do_write(1, 5, 16'h0033);
        do_write(7, 0, 16'h0001);
        soft_pulse();
        @(negedge clk);
        check_pads("R8 retained");
        rd_check(1, 0, 16'h5A5A, "R8 cfg kept");
        rd_check(7, 0, 16'h0001, "R8 retain kept");

        // R9: hard reset ignores retention
        hard_reset();
        check_pads("R9");
        rd_check(1, 0, 16'h0000, "R9 cfg");
        rd_check(1, 5, 16'h00FF, "R9 pull");
        rd_check(7, 0, 16'h0000, "R9 retain");

        // Random mix of writes, peripheral values and pin inputs
        for (int it = 0; it < 300; it++) begin
            int port, rg;
            randomize_alts();
            pad_in = NPINS'({$urandom(), $urandom()});
            port = int'($urandom_range(NP - 1, 0));
            rg   = int'($urandom_range(5, 0));
            do_write(port, rg, 16'($urandom()));
            @(negedge clk);
            check_pads("R2/R3 random");
            check_periph("R10 random");
            port = int'($urandom_range(NP - 1, 0));
            rd_check(port, 2, 16'(pad_in[port*8 +: 8]), "R4 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule